// File: doc/BRIEF.md
# Execute-in-place AHB read bridge

This block sits between an AHB-Lite bus and a serial flash engine, so that a processor can fetch instructions straight out of external flash. Each accepted read is turned into one line request for the engine: the fast-read opcode plus the address of the 16-byte line that holds the requested word. The engine runs the command, address, mode, dummy and data phases, then returns the whole 128-bit line. The bridge keeps HREADYOUT low until that line arrives. It then presents the 32-bit word selected by the transfer's address.

The bridge only reads, and only while execute-in-place operation is on. A write transfer, or a read made while the mode is off, gets the two-cycle AHB ERROR response, and no flash request is made. The bridge also drives the select of the mux that chooses whose requests reach the engine: its own when the mode is on, the register block's when it is off.

The bus address port carries word-address bits only, because the bridge always fetches whole lines and returns whole words.

Top module: `xip_read_bridge`

## Requirements
- R1: An accepted write transfer (HSEL=1, HREADY=1, HTRANS[1]=1, HWRITE=1) gets an ERROR response. In the first data-phase cycle HRESP=1 and HREADYOUT=0, and in the second HRESP=1 and HREADYOUT=1. No flash request is raised.
- R2: An accepted read while `xip_en`=0 gets the same two-cycle ERROR response, and no flash request is raised.
- R3: An accepted read while `xip_en`=1 raises `req_valid` in the next cycle, with `req_opcode`=0x0B. `req_valid` stays high, with `req_addr` unchanged and HREADYOUT low, until `eng_done` is sampled high.
- R4: Every request asks for one full 128-bit line. `req_addr` equals the transfer's byte address with bits [3:0] cleared. Any word within the same 16-byte line yields the same request.
- R5: The returned word is `eng_line[32*k+31 : 32*k]`, where k is byte-address bits [3:2] of the transfer.
- R6: In the cycle after `eng_done` is sampled, HREADYOUT=1, HRESP=0, `req_valid`=0, and HRDATA holds the selected word.
- R7: IDLE (HTRANS=00) and BUSY (HTRANS=01) transfers, and cycles with HSEL=0, get OKAY with zero wait states.
- R8: `mux_sel_xip` equals `xip_en` in every cycle. A value of 1 routes this bridge's requests to the engine, and 0 routes the register block's requests.
- R9: Out of reset, HREADYOUT=1, HRESP=0 and `req_valid`=0.
- R10: A transfer whose address phase coincides with the last cycle of a previous read data phase, or with the second cycle of an ERROR response, is accepted and handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | FLASH_AW-2 | Word-address bits [FLASH_AW-1:2] of the bus address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write when 1 |
| hready | input | 1 | Bus-level ready |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | 1 = ERROR |
| hrdata | output | 32 | Read data |
| xip_en | input | 1 | Execute-in-place mode enable |
| mux_sel_xip | output | 1 | Control-mux select, 1 = this bridge |
| req_valid | output | 1 | Line request to the engine, held until done |
| req_opcode | output | 8 | Flash read opcode (0x0B) |
| req_addr | output | FLASH_AW | 16-byte-aligned flash line address |
| eng_done | input | 1 | One-cycle pulse: line available |
| eng_line | input | 128 | Fetched line, word 0 in bits [31:0] |

## Verification
The assertions check, on every cycle, the shape of the ERROR response and its cause (a write, or a read with the mode off). They also check that a pending request holds its address and keeps wait states until the engine finishes, that completion gives a ready OKAY, and that idle or busy transfers see no wait. The value of HRDATA depends on which word of the fetched line was chosen, and the line address depends on the transfer address. Only the bench's scenarios show these, by comparing them with lines and addresses it computes itself. The same holds for the mux select following the mode under changing settings, and for back-to-back transfers across varied engine latencies.

// File: rtl/xip_read_bridge.sv
module xip_read_bridge #(
  parameter int          FLASH_AW = 24,
  parameter logic [7:0]  READ_OP  = 8'h0B
) (
  input  logic                  hclk,
  input  logic                  hresetn,
  input  logic                  hsel,
  input  logic [FLASH_AW-1:2]   haddr,
  input  logic [1:0]            htrans,
  input  logic                  hwrite,
  input  logic                  hready,
  output logic                  hreadyout,
  output logic                  hresp,
  output logic [31:0]           hrdata,
  input  logic                  xip_en,
  output logic                  mux_sel_xip,
  output logic                  req_valid,
  output logic [7:0]            req_opcode,
  output logic [FLASH_AW-1:0]   req_addr,
  input  logic                  eng_done,
  input  logic [127:0]          eng_line
);
  localparam int LINE_AW = FLASH_AW - 4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ERR1, S_ERR2, S_DATA} st_t;

  st_t                 st;
  logic [LINE_AW-1:0]  line_q;
  logic [1:0]          wsel_q;
  logic [31:0]         word_q;
  logic                accept;

  assign accept = hsel && hready && htrans[1];

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      st     <= S_IDLE;
      line_q <= '0;
      wsel_q <= '0;
      word_q <= '0;
    end else begin
      case (st)
        S_FETCH: if (eng_done) begin
          word_q <= eng_line[32*wsel_q +: 32];
          st     <= S_DATA;
        end
        S_ERR1: st <= S_ERR2;
        default: begin
          if (!accept) st <= S_IDLE;
          else if (hwrite || !xip_en) st <= S_ERR1;
          else begin
            st     <= S_FETCH;
            line_q <= haddr[FLASH_AW-1:4];
            wsel_q <= haddr[3:2];
          end
        end
      endcase
    end
  end

  assign hreadyout   = (st != S_FETCH) && (st != S_ERR1);
  assign hresp       = (st == S_ERR1) || (st == S_ERR2);
  assign hrdata      = (st == S_DATA) ? word_q : 32'h0;
  assign req_valid   = (st == S_FETCH);
  assign req_opcode  = READ_OP;
  assign req_addr    = {line_q, 4'h0};
  assign mux_sel_xip = xip_en;
endmodule

// File: rtl/xip_read_bridge_chk.sv
module xip_read_bridge_chk #(
  parameter int FLASH_AW = 24
) (
  input logic                hclk,
  input logic                hresetn,
  input logic                hsel,
  input logic [1:0]          htrans,
  input logic                hwrite,
  input logic                hready,
  input logic                hreadyout,
  input logic                hresp,
  input logic                xip_en,
  input logic                req_valid,
  input logic [7:0]          req_opcode,
  input logic [FLASH_AW-1:0] req_addr,
  input logic                eng_done
);
  logic acc;
  assign acc = hsel && hready && htrans[1];

  p_err_tail_r1: assert property (@(posedge hclk) disable iff (!hresetn)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  p_write_err_r1: assert property (@(posedge hclk) disable iff (!hresetn)
    (acc && hwrite) |=> (hresp && !hreadyout && !req_valid));

  p_mode_off_err_r2: assert property (@(posedge hclk) disable iff (!hresetn)
    (acc && !hwrite && !xip_en) |=> (hresp && !hreadyout && !req_valid));

  p_read_req_r3: assert property (@(posedge hclk) disable iff (!hresetn)
    (acc && !hwrite && xip_en) |=> (req_valid && req_opcode == 8'h0B && !hreadyout));

  p_req_hold_r3: assert property (@(posedge hclk) disable iff (!hresetn)
    (req_valid && !eng_done) |=> (req_valid && $stable(req_addr) && !hreadyout));

  p_done_ok_r6: assert property (@(posedge hclk) disable iff (!hresetn)
    (req_valid && eng_done) |=> (hreadyout && !hresp && !req_valid));

  p_idle_okay_r7: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && !(hsel && htrans[1])) |=> (hreadyout && !hresp));
endmodule

bind xip_read_bridge xip_read_bridge_chk #(.FLASH_AW(FLASH_AW)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
  .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .xip_en(xip_en),
  .req_valid(req_valid), .req_opcode(req_opcode), .req_addr(req_addr),
  .eng_done(eng_done)
);

// File: tb/xip_read_bridge_tb.sv
module xip_read_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsel = 1'b0;
  logic [AW-1:2] haddr = '0;
  logic [1:0]    htrans = 2'b00;
  logic          hwrite = 1'b0;
  logic          hreadyout, hresp, mux_sel_xip, req_valid;
  logic [31:0]   hrdata;
  logic          xip_en = 1'b0;
  logic [7:0]    req_opcode;
  logic [AW-1:0] req_addr;
  logic          eng_done = 1'b0;
  logic [127:0]  eng_line = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xip_read_bridge #(.FLASH_AW(AW)) u_dut (
    .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hreadyout), .hreadyout(hreadyout), .hresp(hresp),
    .hrdata(hrdata), .xip_en(xip_en), .mux_sel_xip(mux_sel_xip),
    .req_valid(req_valid), .req_opcode(req_opcode), .req_addr(req_addr),
    .eng_done(eng_done), .eng_line(eng_line)
  );

  function automatic logic [31:0] word_of(input logic [AW-5:0] line, input int k);
    return 32'hC3A50000 ^ {8'h00, line} ^ (k * 32'h1111_0101);
  endfunction

  function automatic logic [127:0] line_of(input logic [AW-5:0] line);
    return {word_of(line, 3), word_of(line, 2), word_of(line, 1), word_of(line, 0)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Call at a negedge; returns at a negedge inside the data phase's last cycle.
  task automatic xfer(input logic [AW-1:0] addr, input bit wr, input int delay);
    bit err = wr || !xip_en;
    hsel = 1'b1; htrans = 2'b10; haddr = addr[AW-1:2]; hwrite = wr;
    @(posedge clk); @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
    if (err) begin
      chk(!hreadyout && hresp && !req_valid, wr ? "R1 err first" : "R2 err first",
          {29'd0, hreadyout, hresp, req_valid}, 32'b010);
      @(negedge clk);
      chk(hreadyout && hresp && !req_valid, wr ? "R1 err second" : "R2 err second",
          {29'd0, hreadyout, hresp, req_valid}, 32'b110);
    end else begin
      chk(req_valid && req_opcode == 8'h0B, "R3 request opcode", {24'd0, req_opcode}, 32'h0B);
      chk(req_addr == {addr[AW-1:4], 4'h0}, "R4 line address",
          {8'd0, req_addr}, {8'd0, addr[AW-1:4], 4'h0});
      for (int i = 0; i < delay; i++) begin
        chk(req_valid && !hreadyout && req_addr == {addr[AW-1:4], 4'h0}, "R3 hold",
            {29'd0, req_valid, hreadyout, 1'b0}, 32'b100);
        @(negedge clk);
      end
      eng_done = 1'b1; eng_line = line_of(addr[AW-1:4]);
      @(negedge clk);
      eng_done = 1'b0; eng_line = '0;
      chk(hreadyout && !hresp && !req_valid, "R6 completion", {29'd0, hreadyout, hresp, req_valid}, 32'b100);
      chk(hrdata == word_of(addr[AW-1:4], int'(addr[3:2])), "R5 word select",
          hrdata, word_of(addr[AW-1:4], int'(addr[3:2])));
    end
  endtask

  task automatic idle_cycle(input logic [1:0] tr, input bit sel);
    hsel = sel; htrans = tr; hwrite = 1'b0;
    @(posedge clk); @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    chk(hreadyout && !hresp && !req_valid, "R7 idle/busy okay", {29'd0, hreadyout, hresp, req_valid}, 32'b100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(hreadyout && !hresp && !req_valid, "R9 reset state", {29'd0, hreadyout, hresp, req_valid}, 32'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hreadyout && !hresp && !req_valid, "R9 after reset", {29'd0, hreadyout, hresp, req_valid}, 32'b100);
    chk(mux_sel_xip == 1'b0, "R8 mux off", {31'd0, mux_sel_xip}, 32'd0);

    xfer(24'h000100, 1'b0, 2);           // R2 read with mode off
    xip_en = 1'b1;
    #1 chk(mux_sel_xip == 1'b1, "R8 mux on", {31'd0, mux_sel_xip}, 32'd1);
    xfer(24'h000104, 1'b1, 0);           // R1 write
    xfer(24'h000100, 1'b0, 0);           // R10 back-to-back after error
    xfer(24'h00010C, 1'b0, 3);           // R10 back-to-back after read, R4 same line
    xfer(24'h000108, 1'b0, 1);
    xfer(24'hFFFFFC, 1'b0, 4);           // top of address space
    idle_cycle(2'b00, 1'b1);             // R7 IDLE
    idle_cycle(2'b01, 1'b1);             // R7 BUSY
    idle_cycle(2'b10, 1'b0);             // R7 not selected

    for (int n = 0; n < 80; n++) begin
      logic [AW-1:0] a = AW'($urandom);
      bit w = ($urandom % 5) == 0;
      xip_en = ($urandom % 6) != 0;
      #1 chk(mux_sel_xip == xip_en, "R8 mux follows mode", {31'd0, mux_sel_xip}, {31'd0, xip_en});
      xfer(a, w, int'($urandom % 6));
      if (($urandom % 3) == 0) idle_cycle(2'($urandom % 2), 1'b1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule